// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block takes one request, a byte-range program or a sector-range erase, and turns it into the chain of serial flash commands that the request needs. It drives the command port of a separate serial transfer engine. The engine moves the opcode, the address and any payload on the wire. The engine also fetches program payload bytes from a buffer, at the offset this block hands it. For each command the sequencer waits for the engine's completion pulse and then decides what to send next.

Each program chunk or erased sector is one step. A step opens with a write-enable command and sends the operation. It then reads the status register until the write-in-progress bit clears or a poll budget runs out. A program request is cut so that no chunk crosses a page boundary. A write-disable command closes every request that reached the flash. Requests that are empty, out of range or badly aligned end at once with no traffic on the command port.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are 0. A `req_start` seen while idle is accepted, and `busy` stays 1 until the request ends. `done` is a one-cycle pulse, and `busy` is 0 in that cycle. `err_reject` and `err_timeout` are valid with `done`, hold until the next accepted request, and are cleared when it is accepted.
- R2: A request with `req_len` = 0 raises `done` in the cycle after acceptance, with both error flags 0 and no command issued. This holds for either operation and any address.
- R3: A request is rejected when `req_addr` >= FLASH_BYTES or when `req_len` > FLASH_BYTES - `req_addr`. Rejection means `done` the cycle after acceptance, `err_reject` = 1 and no command issued. A range that ends exactly at the last byte is accepted.
- R4: An erase (`req_erase` = 1) whose address or length is not a multiple of SECTOR_BYTES (4096) is rejected in the same way as R3. Every erase command that is issued carries a sector-aligned address.
- R5: Each step first issues opcode 0x06 with `cmd_addr_en` = 0 and `cmd_wr_len` = 0. It then issues the operation with `cmd_addr_en` = 1 and a 24-bit `cmd_addr`. For a program the operation is opcode 0x02 with `cmd_wr_len` = chunk bytes. For an erase it is opcode 0x20 with `cmd_wr_len` = 0.
- R6: Program chunks never cross a PAGE_BYTES (256) boundary. Each chunk is min(remaining, 256 - address mod 256) bytes. `cmd_src_off` gives the number of request bytes already sent by earlier chunks.
- R7: After each operation, opcode 0x05 is issued with `cmd_rd_stat` = 1. It repeats until bit 0 of `cmd_rdata`, sampled with `cmd_done`, reads 0. All other status bits are ignored.
- R8: If MAX_POLLS consecutive status reads (default 10000) all show bit 0 = 1, the step times out and `err_timeout` is set. A success on exactly the MAX_POLLS-th read is not a timeout. A program timeout skips all remaining chunks.
- R9: An erase timeout on one sector does not stop the request. The remaining sectors are still erased, and `err_timeout` is reported at the end.
- R10: Every request that issued commands ends with exactly one opcode 0x04, after its last step or after an aborted program. `done` follows that command's completion.
- R11: `cmd_valid` and all command fields stay stable until `cmd_ready`. No new command is presented between an accepted command and its `cmd_done`.
- R12: `req_start` is ignored while `busy` is 1. It does not change the command stream, the flags, or the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only while idle |
| req_erase | input | 1 | 1 = sector erase, 0 = program |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_reject | output | 1 | Request refused without traffic |
| err_timeout | output | 1 | At least one status poll budget expired |
| cmd_valid | output | 1 | Command presented to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_opcode | output | 8 | Flash opcode |
| cmd_addr_en | output | 1 | Command carries an address |
| cmd_addr | output | ADDR_W | Flash address |
| cmd_wr_len | output | log2(PAGE_BYTES)+1 | Program payload bytes |
| cmd_src_off | output | ADDR_W+1 | Payload offset inside the request buffer |
| cmd_rd_stat | output | 1 | Command reads one status byte |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_rdata | input | 8 | Status byte, valid with cmd_done |

## Verification
The bench aims at page splits from an unaligned start and a range that ends on the last flash byte. A split that is off by one would cross a page or lose bytes. A range compare that is off by one would refuse a legal tail. Status polls are fed with every bit set except bit 0. A sequencer that tests the whole byte would keep polling. A sector that clears on exactly the last allowed read must not count as a timeout. Two failures are also provoked. An erase failure must let the later sectors run, a program failure must skip them, and both must still close with a single write-disable. Requests poked in while busy must leave the command stream unchanged.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam logic [7:0] OPC_WR_EN     = 8'h06;
    localparam logic [7:0] OPC_WR_DIS    = 8'h04;
    localparam logic [7:0] OPC_RD_STATUS = 8'h05;
    localparam logic [7:0] OPC_PROGRAM   = 8'h02;
    localparam logic [7:0] OPC_ERASE_4K  = 8'h20;

    localparam int BUSY_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } fps_state_e;

    typedef enum logic [1:0] {
        PH_WREN = 2'd0,
        PH_OPER = 2'd1,
        PH_POLL = 2'd2,
        PH_WRDI = 2'd3
    } fps_phase_e;

endpackage

// File: rtl/fps_req_check.sv
module fps_req_check #(
    parameter int ADDR_W       = 24,
    parameter int FLASH_BYTES  = 1 << 20,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   len,
    output logic              is_empty,
    output logic              is_bad
);
    localparam int EXT_W = ADDR_W + 2;
    localparam logic [EXT_W-1:0] FLASH_EXT = EXT_W'(FLASH_BYTES);

    logic [EXT_W-1:0] addr_ext;
    logic [EXT_W-1:0] len_ext;
    logic             out_of_range;
    logic             misaligned;

    assign addr_ext = EXT_W'(addr);
    assign len_ext  = EXT_W'(len);

    // start past the end, or tail past the end (room only meaningful when start is inside)
    assign out_of_range = (addr_ext >= FLASH_EXT) || (len_ext > (FLASH_EXT - addr_ext));

    generate
        if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) == 0) begin : g_pow2
            localparam int SECT_W = $clog2(SECTOR_BYTES);
            assign misaligned = erase &&
                ((addr[SECT_W-1:0] != '0) || (len[SECT_W-1:0] != '0));
        end else begin : g_generic
            assign misaligned = erase &&
                (((32'(addr) % 32'(SECTOR_BYTES)) != 32'd0) ||
                 ((32'(len)  % 32'(SECTOR_BYTES)) != 32'd0));
        end
    endgenerate

    assign is_empty = (len == '0);
    assign is_bad   = out_of_range || misaligned;

endmodule

// File: rtl/fps_step_calc.sv
module fps_step_calc #(
    parameter int ADDR_W       = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic                          erase,
    input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
    input  logic [ADDR_W:0]               remain,
    output logic [ADDR_W:0]               step_len
);
    localparam int LEN_W = ADDR_W + 1;

    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] page_chunk;

    // bytes left before the next page boundary
    assign room       = LEN_W'(PAGE_BYTES) - LEN_W'(page_off);
    assign page_chunk = (remain < room) ? remain : room;
    assign step_len   = erase ? LEN_W'(SECTOR_BYTES) : page_chunk;

endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
    parameter int MAX_POLLS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && !last) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // high while the read now in flight is the final one of the budget
    assign last = (cnt_q == CNT_W'(MAX_POLLS - 1));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int ADDR_W       = 24,
    parameter int FLASH_BYTES  = 1 << 20,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int MAX_POLLS    = 10000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_start,
    input  logic                        req_erase,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [ADDR_W:0]             req_len,
    output logic                        busy,
    output logic                        done,
    output logic                        err_reject,
    output logic                        err_timeout,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [7:0]                  cmd_opcode,
    output logic                        cmd_addr_en,
    output logic [ADDR_W-1:0]           cmd_addr,
    output logic [$clog2(PAGE_BYTES):0] cmd_wr_len,
    output logic [ADDR_W:0]             cmd_src_off,
    output logic                        cmd_rd_stat,
    input  logic                        cmd_done,
    input  logic [7:0]                  cmd_rdata
);
    import fps_pkg::*;

    localparam int LEN_W  = ADDR_W + 1;
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        fps_state_e        st;
        fps_phase_e        ph;
        logic              erase;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  off;
        logic              done;
        logic              rej;
        logic              tout;
    } seq_regs_t;

    seq_regs_t r_d;
    seq_regs_t r_q;

    logic             chk_empty;
    logic             chk_bad;
    logic [LEN_W-1:0] step_len;
    logic             poll_clr;
    logic             poll_tick;
    logic             poll_last;
    logic             advance;
    logic [LEN_W-1:0] rem_after;
    logic             wip;
    logic             unused_status;

    fps_req_check #(
        .ADDR_W      (ADDR_W),
        .FLASH_BYTES (FLASH_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) i_req_check (
        .erase   (req_erase),
        .addr    (req_addr),
        .len     (req_len),
        .is_empty(chk_empty),
        .is_bad  (chk_bad)
    );

    fps_step_calc #(
        .ADDR_W      (ADDR_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) i_step_calc (
        .erase   (r_q.erase),
        .page_off(r_q.addr[PAGE_W-1:0]),
        .remain  (r_q.remain),
        .step_len(step_len)
    );

    fps_poll_timer #(
        .MAX_POLLS(MAX_POLLS)
    ) i_poll_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(poll_clr),
        .tick (poll_tick),
        .last (poll_last)
    );

    assign wip           = cmd_rdata[BUSY_BIT];
    assign unused_status = ^cmd_rdata[7:1];
    assign rem_after     = r_q.remain - step_len;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        poll_clr  = 1'b0;
        poll_tick = 1'b0;
        advance   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_start) begin
                    r_d.rej  = 1'b0;
                    r_d.tout = 1'b0;
                    if (chk_empty) begin
                        r_d.done = 1'b1;
                    end else if (chk_bad) begin
                        r_d.done = 1'b1;
                        r_d.rej  = 1'b1;
                    end else begin
                        r_d.st     = ST_SEND;
                        r_d.ph     = PH_WREN;
                        r_d.erase  = req_erase;
                        r_d.addr   = req_addr;
                        r_d.remain = req_len;
                        r_d.off    = '0;
                    end
                end
            end

            ST_SEND: begin
                if (cmd_ready) begin
                    r_d.st = ST_WAIT;
                end
            end

            ST_WAIT: begin
                if (cmd_done) begin
                    r_d.st = ST_SEND;
                    unique case (r_q.ph)
                        PH_WREN: r_d.ph = PH_OPER;
                        PH_OPER: begin
                            r_d.ph   = PH_POLL;
                            poll_clr = 1'b1;
                        end
                        PH_POLL: begin
                            poll_tick = 1'b1;
                            if (!wip) begin
                                advance = 1'b1;
                            end else if (poll_last) begin
                                r_d.tout = 1'b1;
                                if (r_q.erase) begin
                                    advance = 1'b1;   // skip this sector, go on
                                end else begin
                                    r_d.ph = PH_WRDI; // abort program
                                end
                            end
                        end
                        PH_WRDI: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                        default: r_d.ph = PH_WRDI;
                    endcase

                    if (advance) begin
                        r_d.addr   = r_q.addr + step_len[ADDR_W-1:0];
                        r_d.off    = r_q.off + step_len;
                        r_d.remain = rem_after;
                        r_d.ph     = (rem_after == '0) ? PH_WRDI : PH_WREN;
                    end
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.ph)
            PH_WREN: cmd_opcode = OPC_WR_EN;
            PH_OPER: cmd_opcode = r_q.erase ? OPC_ERASE_4K : OPC_PROGRAM;
            PH_POLL: cmd_opcode = OPC_RD_STATUS;
            default: cmd_opcode = OPC_WR_DIS;
        endcase
    end

    assign cmd_valid   = (r_q.st == ST_SEND);
    assign cmd_addr_en = (r_q.ph == PH_OPER);
    assign cmd_addr    = r_q.addr;
    assign cmd_wr_len  = (r_q.ph == PH_OPER && !r_q.erase) ? step_len[PAGE_W:0] : '0;
    assign cmd_src_off = r_q.off;
    assign cmd_rd_stat = (r_q.ph == PH_POLL);

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign err_reject  = r_q.rej;
    assign err_timeout = r_q.tout;

endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk #(
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            busy,
    input logic                            done,
    input logic                            cmd_valid,
    input logic                            cmd_ready,
    input logic [7:0]                      cmd_opcode,
    input logic                            cmd_addr_en,
    input logic [$clog2(SECTOR_BYTES)-1:0] cmd_addr_lo,
    input logic [$clog2(PAGE_BYTES):0]     cmd_wr_len,
    input logic                            cmd_done
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            pend_q <= 1'b1;
        end else if (cmd_done) begin
            pend_q <= 1'b0;
        end
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) &&
            $stable(cmd_addr_lo) && $stable(cmd_wr_len));

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !pend_q);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    cmd_in_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R5
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr_en == (cmd_opcode == 8'h02 || cmd_opcode == 8'h20)));

    // R6
    page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_opcode == 8'h02 |->
            cmd_wr_len != '0 &&
            (32'(cmd_addr_lo[PAGE_W-1:0]) + 32'(cmd_wr_len)) <= 32'(PAGE_BYTES));

    // R4
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_opcode == 8'h20 |-> cmd_addr_lo == '0);

endmodule

bind flash_prog_seq fps_seq_chk #(
    .PAGE_BYTES  (PAGE_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES)
) i_fps_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_opcode (cmd_opcode),
    .cmd_addr_en(cmd_addr_en),
    .cmd_addr_lo(cmd_addr[$clog2(SECTOR_BYTES)-1:0]),
    .cmd_wr_len (cmd_wr_len),
    .cmd_done   (cmd_done)
);

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 12;
    localparam int NEVER      = 1000000;

    typedef struct {
        logic [7:0] op;
        bit         aen;
        int         addr;
        int         wlen;
        int         off;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_start;
    logic        req_erase;
    logic [23:0] req_addr;
    logic [24:0] req_len;
    logic        busy, done, err_reject, err_timeout;
    logic        cmd_valid, cmd_ready, cmd_addr_en, cmd_rd_stat, cmd_done;
    logic [7:0]  cmd_opcode, cmd_rdata;
    logic [23:0] cmd_addr;
    logic [8:0]  cmd_wr_len;
    logic [24:0] cmd_src_off;

    exp_t exp_q[$];
    int   busy_q[$];
    int   checks  = 0;
    int   errors  = 0;
    int   cmd_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_prog_seq #(.MAX_POLLS(MAXP)) i_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_erase(req_erase),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .err_reject(err_reject), .err_timeout(err_timeout), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_addr_en(cmd_addr_en),
        .cmd_addr(cmd_addr), .cmd_wr_len(cmd_wr_len), .cmd_src_off(cmd_src_off),
        .cmd_rd_stat(cmd_rd_stat), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] op, input bit aen, input int addr,
                        input int wlen, input int off, input string tag);
        exp_t e;
        e.op = op; e.aen = aen; e.addr = addr; e.wlen = wlen; e.off = off; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // one step: write enable, operation, status polls
    task automatic exp_step(input logic [7:0] op, input int addr, input int wlen,
                            input int off, input int b);
        int n;
        n = (b < MAXP) ? b + 1 : MAXP;
        push(8'h06, 0, 0, 0, 0, "R5");
        push(op, 1, addr, wlen, off, (op == 8'h02) ? "R6" : "R5");
        for (int i = 0; i < n; i++) push(8'h05, 0, 0, 0, 0, (b >= MAXP) ? "R8" : "R7");
        busy_q.push_back(b);
    endtask

    task automatic exp_program(input int addr, input int len, input int b_first, input int b_rest);
        int a, rem, off, b, c;
        a = addr; rem = len; off = 0; b = b_first;
        while (rem > 0) begin
            c = 256 - (a % 256);
            if (rem < c) c = rem;
            exp_step(8'h02, a, c, off, b);
            if (b >= MAXP) break;   // R8 abort
            a += c; off += c; rem -= c; b = b_rest;
        end
        push(8'h04, 0, 0, 0, 0, "R10");
    endtask

    task automatic exp_erase(input int addr, input int nsect, input int b0, input int b1, input int b2);
        int bl[3];
        bl[0] = b0; bl[1] = b1; bl[2] = b2;
        for (int s = 0; s < nsect; s++) exp_step(8'h20, addr + s * 4096, 0, 0, bl[s]);
        push(8'h04, 0, 0, 0, 0, "R10");
    endtask

    task automatic run_req(input logic er, input int addr, input int len, input bit e_rej,
                           input bit e_to, input bit quick, input bit poke, input string tag);
        int cyc, c0, dones;
        c0 = cmd_cnt;
        @(negedge clk);
        req_start = 1'b1; req_erase = er; req_addr = addr[23:0]; req_len = len[24:0];
        @(negedge clk);
        req_start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            if (poke && cyc == 3) begin
                req_start = 1'b1; req_erase = 1'b1; req_addr = 24'h008000; req_len = 25'h1000;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_start = 1'b0;
        chk(done == 1'b1, tag, "done seen", done, 1);
        if (quick) begin
            chk(cyc == 1, tag, "done latency", cyc, 1);
            chk(cmd_cnt == c0, tag, "commands issued", cmd_cnt - c0, 0);
        end
        chk(err_reject == e_rej, tag, "err_reject", err_reject, e_rej);
        chk(err_timeout == e_to, tag, "err_timeout", err_timeout, e_to);
        chk(exp_q.size() == 0, tag, "missing commands", exp_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R1", "done pulse width", done, 0);
        chk(busy == 1'b0, "R1", "busy after done", busy, 0);
        if (poke) begin
            dones = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || busy) dones++;
            end
            chk(dones == 0, "R12", "activity after poked request", dones, 0);
        end
    endtask

    // monitor and flash responder
    initial begin
        int         cur_busy;
        exp_t       e;
        logic [7:0] op;
        cur_busy = 0;
        cmd_ready = 1'b0; cmd_done = 1'b0; cmd_rdata = 8'h00;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                cmd_cnt++;
                op = cmd_opcode;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected command opcode", op, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(op == e.op, e.tag, "opcode", op, e.op);
                    chk(cmd_addr_en == e.aen, e.tag, "addr_en", cmd_addr_en, e.aen);
                    if (e.aen) chk(cmd_addr == e.addr[23:0], e.tag, "address", cmd_addr, e.addr);
                    chk(int'(cmd_wr_len) == e.wlen, e.tag, "wr_len", cmd_wr_len, e.wlen);
                    if (e.wlen != 0) chk(int'(cmd_src_off) == e.off, e.tag, "src_off", cmd_src_off, e.off);
                    chk(cmd_rd_stat == (e.op == 8'h05), "R7", "rd_stat", cmd_rd_stat, e.op == 8'h05);
                end
                if (op == 8'h02 || op == 8'h20) cur_busy = (busy_q.size() > 0) ? busy_q.pop_front() : 0;
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                chk(!cmd_valid, "R11", "valid while outstanding", cmd_valid, 0);
                for (int s = 0; s < cmd_cnt % 3; s++) begin
                    @(negedge clk);
                    chk(!cmd_valid, "R11", "valid while outstanding", cmd_valid, 0);
                end
                if (op == 8'h05) begin
                    cmd_rdata = (cur_busy > 0) ? 8'h03 : 8'hFE;
                    if (cur_busy > 0) cur_busy--;
                end else begin
                    cmd_rdata = 8'hFF;
                end
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_start = 1'b0; req_erase = 1'b0; req_addr = '0; req_len = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 empty requests, even at an unaligned erase address
        run_req(1'b0, 32'h0001_0000, 0, 0, 0, 1, 0, "R2");
        run_req(1'b1, 32'h0000_0123, 0, 0, 0, 1, 0, "R2");
        // R3 range rejects
        run_req(1'b0, 32'h0010_0000, 1, 1, 0, 1, 0, "R3");
        run_req(1'b0, 32'h000F_F000, 32'h1001, 1, 0, 1, 0, "R3");
        // R4 alignment rejects
        run_req(1'b1, 32'h0000_1800, 32'h1000, 1, 0, 1, 0, "R4");
        run_req(1'b1, 32'h0000_1000, 32'h1800, 1, 0, 1, 0, "R4");
        // R6 unaligned program across one boundary
        exp_program(32'h1F0, 48, 2, 0);
        run_req(1'b0, 32'h1F0, 48, 0, 0, 0, 0, "R6");
        // R6 aligned program over three pages
        exp_program(32'h300, 600, 1, 3);
        run_req(1'b0, 32'h300, 600, 0, 0, 0, 0, "R6");
        // R3 tail ending on the last byte is legal
        exp_program(32'hFFF00, 256, 0, 0);
        run_req(1'b0, 32'hFFF00, 256, 0, 0, 0, 0, "R3");
        // R7 / R8 erase, second sector clears on the last allowed poll
        exp_erase(32'h2000, 2, 3, MAXP - 1, 0);
        run_req(1'b1, 32'h2000, 32'h2000, 0, 0, 0, 0, "R8");
        // R8 program timeout aborts remaining chunks
        exp_program(32'h10, 300, NEVER, 0);
        run_req(1'b0, 32'h10, 300, 0, 1, 0, 0, "R8");
        // R9 erase timeout continues with later sectors
        exp_erase(32'h5000, 3, NEVER, 1, 0);
        run_req(1'b1, 32'h5000, 32'h3000, 0, 1, 0, 0, "R9");
        // R12 start pulse while busy is ignored; R1 flags cleared on accept
        exp_program(32'h40, 64, 4, 0);
        run_req(1'b0, 32'h40, 64, 0, 0, 0, 1, "R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule